// File: doc/BRIEF.md
# Dual-Channel Byte-Loaded Converter Register Front End

This block holds the digital register state of a two-channel, 12-bit converter that a host loads over an 8-bit parallel bus. Every channel owns two input registers, an 8-bit low byte and a 4-bit high nibble, plus a 12-bit output register whose value drives the converter. Data is right-justified. A host fills the input registers of both channels one byte at a time. A single update strobe then moves both channels into their output registers on the same clock, so the two outputs never show a half-loaded code.

All control inputs are active low: chip select, write, update and clear. Two address lines pick the input register. When update is asserted together with a write, the output registers become transparent: bus data written to an input register reaches the output on the next clock. The clear input empties every register. Its assertion acts at once, with no clock. Its release is synchronised to the block clock. Strobes are sampled as levels on each rising clock edge. A one-cycle flag marks the start of each simultaneous transfer.

Top module: `dual_byte_dac_regs`

## Requirements
- R1: While `clr_n` is low, every input register and both outputs are zero. This takes effect as soon as `clr_n` falls, without waiting for a clock edge.
- R2: A low-byte write stores bus bits 7..0 as bits 7..0 of the addressed channel.
- R3: A high-nibble write stores bus bits 3..0 as bits 11..8 of the addressed channel. Bus bits 7..4 are dropped.
- R4: With `cs_n` and `wr_n` low, the `addr` code selects one input register: 0 is channel A low byte, 1 is A high nibble, 2 is B low byte, 3 is B high nibble. The other three registers keep their values.
- R5: Input-register writes with `upd_n` high leave both outputs unchanged, whichever order the two bytes arrive in.
- R6: With `wr_n` and `upd_n` low and `cs_n` high, both outputs load their channel's {high nibble, low byte} on the same clock edge, whatever `addr` holds.
- R7: With `cs_n`, `wr_n` and `upd_n` all low, the addressed input register takes the bus, and both outputs load on the same edge from the input registers including that new value.
- R8: With `wr_n` high, or with `cs_n` and `upd_n` both high, no register changes.
- R9: `upd_pulse` is high for exactly one cycle per R6 strobe. It is high in the cycle in which the outputs first show the transferred values. It stays low during R7 writes.
- R10: After `clr_n` rises, registers stay clear through two rising clock edges. A strobe can first act on the third edge.
- R11: A write pulse and a clear pulse each last at least 80 ns. A qualified write keeps its bus data stable for at least 60 ns before `wr_n` rises and at least 25 ns after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| clr_n | input | 1 | Clear, active low: asserts without a clock, releases in step with the clock |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low, sampled as a level |
| upd_n | input | 1 | Update, active low |
| addr | input | 2 | Input register select |
| bus_d | input | 8 | Parallel data bus |
| dac_a | output | 12 | Channel A output register |
| dac_b | output | 12 | Channel B output register |
| upd_pulse | output | 1 | One-cycle flag for each simultaneous transfer |

## Verification
The bench sweeps both channels with many 12-bit codes, written low byte first or high nibble first. It checks that the outputs do not move until the transfer strobe. A design that forwarded input writes early would show a torn code on the outputs.

Each transfer uses a different address, which would expose a design that lets `addr` gate the transfer. A high-nibble write carries ones in bus bits 7..4 to catch a nibble taken from the wrong byte lane.

Transparent writes are checked on the first cycle after the edge, and the other channel must load too. Clear is dropped between edges to prove it needs no clock. It is released together with a pending write to confirm the two-edge hold-off. Strobes that should do nothing are then made visible through a later transfer.

// File: rtl/dbd_pkg.sv
package dbd_pkg;
   // input-register slots, in address order
   typedef enum logic [1:0] {
      SLOT_A_LO = 2'd0,
      SLOT_A_HI = 2'd1,
      SLOT_B_LO = 2'd2,
      SLOT_B_HI = 2'd3
   } slot_e;

   localparam int SLOTS_PER_CH = 2;

   function automatic int cycles_for_ns(input int ns, input int period_ns);
      return (ns + period_ns - 1) / period_ns;
   endfunction
endpackage

// File: rtl/dbd_clr_sync.sv
module dbd_clr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic clr_n,
   output logic rst_ok
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 1) begin : g_bad
         $error("dbd_clr_sync: STAGES must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) chain <= '0;
      else        chain <= {chain[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], 1'b1} & {STAGES{1'b1}};
   end

   assign rst_ok = chain[STAGES-1];
endmodule

// File: rtl/dbd_decode.sv
module dbd_decode #(
   parameter int N_SLOT = 4,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_ok,
   input  logic              cs_n,
   input  logic              wr_n,
   input  logic              upd_n,
   input  logic [ADDR_W-1:0] addr,
   output logic [N_SLOT-1:0] slot_we,
   output logic              load,
   output logic              upd_pulse
);
   logic sel_write;
   logic xfer_now;
   logic xfer_prev;

   generate
      if (N_SLOT > (1 << ADDR_W)) begin : g_bad
         $error("dbd_decode: address too narrow for slot count");
      end
   endgenerate

   assign sel_write = !cs_n && !wr_n;
   assign load      = !wr_n && !upd_n;
   assign xfer_now  = load && cs_n;

   generate
      for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
         assign slot_we[s] = sel_write && (addr == ADDR_W'(s));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_ok) begin
      if (!rst_ok) begin
         xfer_prev <= 1'b0;
         upd_pulse <= 1'b0;
      end else begin
         xfer_prev <= xfer_now;
         upd_pulse <= xfer_now && !xfer_prev;
      end
   end
endmodule

// File: rtl/dbd_channel.sv
module dbd_channel #(
   parameter int BUS_W = 8,
   parameter int DAC_W = 12
) (
   input  logic             clk,
   input  logic             rst_ok,
   input  logic             lo_we,
   input  logic             hi_we,
   input  logic             load,
   input  logic [BUS_W-1:0] din,
   output logic [DAC_W-1:0] dac
);
   localparam int HI_W = DAC_W - BUS_W;

   logic [BUS_W-1:0] lo_q, lo_nx;
   logic [HI_W-1:0]  hi_q, hi_nx;

   // right-justified: upper lanes of the bus are dropped on nibble writes
   assign lo_nx = lo_we ? din : lo_q;
   assign hi_nx = hi_we ? din[HI_W-1:0] : hi_q;

   always_ff @(posedge clk or negedge rst_ok) begin
      if (!rst_ok) begin
         lo_q <= '0;
         hi_q <= '0;
         dac  <= '0;
      end else begin
         lo_q <= lo_nx;
         hi_q <= hi_nx;
         if (load) dac <= {hi_nx, lo_nx};
      end
   end
endmodule

// File: rtl/dual_byte_dac_regs.sv
module dual_byte_dac_regs #(
   parameter int BUS_W       = 8,
   parameter int DAC_W       = 12,
   parameter int SYNC_STAGES = 2,
   parameter int CLK_NS      = 10
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic             cs_n,
   input  logic             wr_n,
   input  logic             upd_n,
   input  logic [1:0]       addr,
   input  logic [BUS_W-1:0] bus_d,
   output logic [DAC_W-1:0] dac_a,
   output logic [DAC_W-1:0] dac_b,
   output logic             upd_pulse
);
   import dbd_pkg::*;

   localparam int N_CH   = 2;
   localparam int N_SLOT = N_CH * SLOTS_PER_CH;
   localparam int ADDR_W = $clog2(N_SLOT);

   generate
      if (DAC_W <= BUS_W || DAC_W > 2 * BUS_W) begin : g_bad_w
         $error("dual_byte_dac_regs: DAC_W must lie in (BUS_W, 2*BUS_W]");
      end
      if (ADDR_W != 2) begin : g_bad_a
         $error("dual_byte_dac_regs: address port is two bits");
      end
      if (CLK_NS < 1) begin : g_bad_clk
         $error("dual_byte_dac_regs: CLK_NS must be positive");
      end
   endgenerate

   logic              rst_ok;
   logic [N_SLOT-1:0] slot_we;
   logic              load;
   logic [DAC_W-1:0]  dac_v [N_CH];

   dbd_clr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .clr_n  (clr_n),
      .rst_ok (rst_ok)
   );

   dbd_decode #(.N_SLOT(N_SLOT), .ADDR_W(ADDR_W)) u_dec (
      .clk       (clk),
      .rst_ok    (rst_ok),
      .cs_n      (cs_n),
      .wr_n      (wr_n),
      .upd_n     (upd_n),
      .addr      (addr),
      .slot_we   (slot_we),
      .load      (load),
      .upd_pulse (upd_pulse)
   );

   generate
      for (genvar c = 0; c < N_CH; c++) begin : g_ch
         dbd_channel #(.BUS_W(BUS_W), .DAC_W(DAC_W)) u_ch (
            .clk    (clk),
            .rst_ok (rst_ok),
            .lo_we  (slot_we[c*SLOTS_PER_CH]),
            .hi_we  (slot_we[c*SLOTS_PER_CH+1]),
            .load   (load),
            .din    (bus_d),
            .dac    (dac_v[c])
         );
      end
   endgenerate

   assign dac_a = dac_v[0];
   assign dac_b = dac_v[1];
endmodule

// File: rtl/dbd_checker.sv
module dbd_checker #(
   parameter int BUS_W  = 8,
   parameter int DAC_W  = 12,
   parameter int CLK_NS = 10
) (
   input logic             clk,
   input logic             clr_n,
   input logic             rst_ok,
   input logic             cs_n,
   input logic             wr_n,
   input logic             upd_n,
   input logic [1:0]       addr,
   input logic [BUS_W-1:0] bus_d,
   input logic [DAC_W-1:0] dac_a,
   input logic [DAC_W-1:0] dac_b,
   input logic             upd_pulse
);
   localparam int WR_CYC    = dbd_pkg::cycles_for_ns(80, CLK_NS);
   localparam int CLR_CYC   = dbd_pkg::cycles_for_ns(80, CLK_NS);
   localparam int SETUP_CYC = dbd_pkg::cycles_for_ns(60, CLK_NS);
   localparam int HOLD_CYC  = dbd_pkg::cycles_for_ns(25, CLK_NS);

   logic [7:0] wr_low_cnt, clr_low_cnt, stable_cnt, hold_cnt;
   logic [BUS_W-1:0] bus_q;
   logic wr_q, cs_q;

   always_ff @(posedge clk) begin
      bus_q <= bus_d;
      wr_q  <= wr_n;
      cs_q  <= cs_n;
      clr_low_cnt <= clr_n ? 8'd0 : (clr_low_cnt == 8'hFF ? clr_low_cnt : clr_low_cnt + 8'd1);
   end

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) begin
         wr_low_cnt <= '0;
         stable_cnt <= '0;
         hold_cnt   <= '0;
      end else begin
         wr_low_cnt <= wr_n ? 8'd0 : (wr_low_cnt == 8'hFF ? wr_low_cnt : wr_low_cnt + 8'd1);
         stable_cnt <= (bus_d != bus_q) ? 8'd0 : (stable_cnt == 8'hFF ? stable_cnt : stable_cnt + 8'd1);
         if (wr_n && !wr_q && !cs_q) hold_cnt <= 8'(HOLD_CYC);
         else if (hold_cnt != 0)     hold_cnt <= hold_cnt - 8'd1;
      end
   end

   p_clear_zero_r1: assert property (@(posedge clk) !clr_n |-> (dac_a == '0 && dac_b == '0));
   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!clr_n)
      (wr_n || (cs_n && upd_n)) |=> ($stable(dac_a) && $stable(dac_b)));
   p_no_early_out_r5: assert property (@(posedge clk) disable iff (!clr_n)
      (!cs_n && !wr_n && upd_n) |=> ($stable(dac_a) && $stable(dac_b)));
   p_transparent_lo_r7: assert property (@(posedge clk) disable iff (!clr_n)
      (rst_ok && !cs_n && !wr_n && !upd_n && addr == 2'd0) |=> (dac_a[BUS_W-1:0] == $past(bus_d)));
   p_pulse_single_r9: assert property (@(posedge clk) disable iff (!clr_n)
      upd_pulse |=> !upd_pulse);
   p_pulse_cause_r9: assert property (@(posedge clk) disable iff (!clr_n)
      upd_pulse |-> $past(cs_n && !wr_n && !upd_n));
   p_held_clear_r10: assert property (@(posedge clk) disable iff (!clr_n)
      !rst_ok |=> (dac_a == '0 && dac_b == '0));
   p_wr_width_r11: assert property (@(posedge clk) disable iff (!clr_n)
      (wr_n && !wr_q) |-> (wr_low_cnt >= 8'(WR_CYC)));
   p_clr_width_r11: assert property (@(posedge clk)
      (clr_n && clr_low_cnt != 0) |-> (clr_low_cnt >= 8'(CLR_CYC)));
   p_setup_r11: assert property (@(posedge clk) disable iff (!clr_n)
      (wr_n && !wr_q && !cs_q) |-> (stable_cnt >= 8'(SETUP_CYC)));
   p_hold_r11: assert property (@(posedge clk) disable iff (!clr_n)
      (hold_cnt != 0) |-> $stable(bus_d));
endmodule

bind dual_byte_dac_regs dbd_checker #(.BUS_W(BUS_W), .DAC_W(DAC_W), .CLK_NS(CLK_NS)) u_chk (
   .clk       (clk),
   .clr_n     (clr_n),
   .rst_ok    (rst_ok),
   .cs_n      (cs_n),
   .wr_n      (wr_n),
   .upd_n     (upd_n),
   .addr      (addr),
   .bus_d     (bus_d),
   .dac_a     (dac_a),
   .dac_b     (dac_b),
   .upd_pulse (upd_pulse)
);

// File: tb/dual_byte_dac_regs_test.sv
module dual_byte_dac_regs_test;
   localparam int CLK_NS = 10;

   logic clk = 1'b0;
   logic clr_n, cs_n, wr_n, upd_n;
   logic [1:0] addr;
   logic [7:0] bus_d;
   logic [11:0] dac_a, dac_b;
   logic upd_pulse;

   int n_chk = 0;
   int n_bad = 0;

   // bench model
   logic [7:0] m_lo [2];
   logic [3:0] m_hi [2];
   logic [11:0] m_dac [2];

   always #(CLK_NS/2) clk = ~clk;

   dual_byte_dac_regs #(.CLK_NS(CLK_NS)) uut (
      .clk(clk), .clr_n(clr_n), .cs_n(cs_n), .wr_n(wr_n), .upd_n(upd_n),
      .addr(addr), .bus_d(bus_d), .dac_a(dac_a), .dac_b(dac_b), .upd_pulse(upd_pulse)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_out(input string tag);
      chk(dac_a == m_dac[0], {tag, " dac_a"}, dac_a, m_dac[0]);
      chk(dac_b == m_dac[1], {tag, " dac_b"}, dac_b, m_dac[1]);
   endtask

   task automatic model_clear();
      for (int c = 0; c < 2; c++) begin
         m_lo[c] = '0; m_hi[c] = '0; m_dac[c] = '0;
      end
   endtask

   // one strobe: wr low for 8 edges, data held 5 cycles after release
   task automatic strobe(input bit cs, input bit upd, input logic [1:0] a,
                         input logic [7:0] d, input string tag);
      int pulses;
      bit exp_pulse;
      exp_pulse = cs && !upd;
      if (!cs) begin
         if (a[0]) m_hi[a[1]] = d[3:0];
         else      m_lo[a[1]] = d;
      end
      if (!upd && !(cs && upd))
         for (int c = 0; c < 2; c++) m_dac[c] = {m_hi[c], m_lo[c]};
      @(negedge clk);
      cs_n = cs; upd_n = upd; addr = a; bus_d = d; wr_n = 1'b0;
      @(negedge clk);
      chk_out(tag);
      chk(upd_pulse == exp_pulse, "R9 pulse on first cycle", upd_pulse, exp_pulse);
      pulses = upd_pulse;
      for (int i = 0; i < 7; i++) begin
         @(negedge clk);
         pulses += upd_pulse;
      end
      wr_n = 1'b1;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         pulses += upd_pulse;
      end
      cs_n = 1'b1; upd_n = 1'b1;
      chk(pulses == int'(exp_pulse), "R9 pulse count", pulses, exp_pulse);
      chk_out({tag, " after"});
   endtask

   task automatic load12(input int ch, input logic [11:0] v, input bit hi_first);
      if (hi_first) begin
         strobe(1'b0, 1'b1, {ch[0], 1'b1}, {4'hF, v[11:8]}, "R3 R5 hi write");
         strobe(1'b0, 1'b1, {ch[0], 1'b0}, v[7:0], "R2 R5 lo write");
      end else begin
         strobe(1'b0, 1'b1, {ch[0], 1'b0}, v[7:0], "R2 R5 lo write");
         strobe(1'b0, 1'b1, {ch[0], 1'b1}, {4'hA, v[11:8]}, "R3 R5 hi write");
      end
   endtask

   initial begin
      #(CLK_NS * 20000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      clr_n = 1'b0; cs_n = 1'b1; wr_n = 1'b1; upd_n = 1'b1; addr = '0; bus_d = '0;
      model_clear();
      repeat (10) @(negedge clk);
      chk_out("R1 reset state");
      chk(upd_pulse == 1'b0, "R1 pulse in reset", upd_pulse, 0);
      clr_n = 1'b1;
      repeat (4) @(negedge clk);

      // R2 R3 R4 R5 R6 sweep over both channels, both byte orders
      for (int k = 0; k < 12; k++) begin
         logic [11:0] va, vb;
         va = 12'((k * 331 + 7) % 4096);
         vb = 12'((k * 1187 + 2900) % 4096);
         load12(0, va, k[0]);
         load12(1, vb, !k[0]);
         strobe(1'b1, 1'b0, 2'(k), 8'(k * 29), "R6 transfer any addr");
         chk(dac_a == va, "R4 R6 channel A code", dac_a, va);
         chk(dac_b == vb, "R4 R6 channel B code", dac_b, vb);
      end

      // R8: cs and upd high with wr low leaves input registers as they were
      strobe(1'b1, 1'b1, 2'd0, 8'h3C, "R8 cs upd high");
      strobe(1'b1, 1'b1, 2'd3, 8'hC3, "R8 cs upd high");
      // R8: wr high with chip select low and changing data
      @(negedge clk);
      cs_n = 1'b0; upd_n = 1'b0;
      for (int i = 0; i < 16; i++) begin
         addr = 2'(i); bus_d = 8'(i * 17 + 1);
         @(negedge clk);
      end
      cs_n = 1'b1; upd_n = 1'b1;
      repeat (2) @(negedge clk);
      chk_out("R8 wr high no change");
      strobe(1'b1, 1'b0, 2'd2, 8'h00, "R8 inputs brought out");

      // R7 transparent writes: both channels load
      strobe(1'b0, 1'b1, 2'd2, 8'h11, "R5 staged B lo");
      strobe(1'b0, 1'b0, 2'd1, 8'hE7, "R7 transparent A hi");
      chk(dac_b[7:0] == 8'h11, "R7 other channel loads", dac_b, 12'h011);
      strobe(1'b0, 1'b0, 2'd0, 8'h5A, "R7 transparent A lo");
      strobe(1'b0, 1'b0, 2'd3, 8'h96, "R7 transparent B hi");

      // R1: clear acts between edges without a clock
      @(negedge clk);
      #2 clr_n = 1'b0;
      #1;
      model_clear();
      chk(dac_a == 0 && dac_b == 0, "R1 async clear", {dac_a, dac_b}, 0);
      repeat (10) @(negedge clk);
      chk_out("R1 held clear");

      // R10: release with a transparent write pending
      clr_n = 1'b1; cs_n = 1'b0; upd_n = 1'b0; wr_n = 1'b0; addr = 2'd0; bus_d = 8'hA5;
      @(negedge clk);
      chk(dac_a == 0, "R10 first edge after release", dac_a, 0);
      @(negedge clk);
      chk(dac_a == 0, "R10 second edge after release", dac_a, 0);
      @(negedge clk);
      chk(dac_a == 12'h0A5, "R10 third edge acts", dac_a, 12'h0A5);
      chk(dac_b == 0, "R10 channel B", dac_b, 0);
      repeat (5) @(negedge clk);
      wr_n = 1'b1;
      repeat (5) @(negedge clk);
      cs_n = 1'b1; upd_n = 1'b1;
      m_lo[0] = 8'hA5;
      m_dac[0] = 12'h0A5;
      chk_out("R10 settled");

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule